// File: doc/BRIEF.md
# Serial Auto-Baud Synchronizer

This block watches an idle-high serial receive line until a host sends a fixed sync character. The character is 0x7F framed with a start bit, eight data bits sent LSB first, an even parity bit and one stop bit. The block counts system-clock cycles across the character and derives a per-bit divisor from that count. It then checks the remainder of the frame. If the frame is good, it sends an acknowledge byte back at the measured rate.

When the last bit of the acknowledge has been sent, the block raises `locked`. From then on it holds the divisor steady for a downstream UART and ignores further line activity until reset. Frames whose timing falls outside a configured window are treated as noise and dropped without comment. Frames with a bad parity bit or a bad stop bit produce a one-cycle error pulse, and the block goes back to waiting for a sync character.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, `tx_out` is high, `locked` and `error` are low, and `divisor` is zero.
- R2: The block measures the interval N, in clock cycles, between the falling edge of the start bit and the falling edge of data bit 7. For 0x7F these two edges are exactly eight bit times apart. The reported divisor is N shifted right by 3.
- R3: The parity bit is sampled at mid-bit and must be 1. If it is 0, `error` pulses high for exactly one cycle and the block returns to waiting for a new sync character.
- R4: The stop bit is sampled at mid-bit and must be 1. If it is 0, `error` pulses for one cycle and the block returns to waiting.
- R5: An interval with N < MIN_CNT is dropped silently, and so is an interval with N > MAX_CNT. In either case there is no error pulse and no transmission, and the block keeps waiting. The interval N = MIN_CNT is accepted, and so is N = MAX_CNT.
- R6: After a good sync frame, `tx_out` sends a low start bit, then 0x79 LSB first, then an even parity bit (1) and a high stop bit. Each bit lasts `divisor` cycles.
- R7: `locked` stays low until the acknowledge stop bit has been sent in full. It then rises and stays high until reset, and `divisor` holds its value while `locked` is high.
- R8: Once the block is locked, traffic on `rx_in` has no effect: `tx_out` stays high, `error` stays low, and `divisor` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| tx_out | output | 1 | Serial transmit line carrying the acknowledge |
| divisor | output | $clog2(MAX_CNT+1)-3 | Measured clock cycles per bit |
| locked | output | 1 | Rate measured and acknowledge sent |
| error | output | 1 | One-cycle pulse on a parity or stop-bit failure |

## Verification
Both falling edges pass through the same three-register path of synchronizer and edge detector, so the measured interval is exactly eight bit times when the bench drives bits of a whole number of cycles. The parity bit is sampled 1.5 bit times after the bit-7 edge is detected, and the stop bit one bit time after that. The acknowledge start bit begins on the next cycle, and `locked` rises one cycle after the acknowledge stop bit ends. The bench finds the reply's first falling edge on a negative clock edge, then samples each reply bit at its middle, checks `locked` low at mid-stop, and checks it high one full bit time later. This keeps every check clear of the edges where the values change.

// File: rtl/autobaud_sync.sv
module autobaud_sync #(
  parameter int MIN_CNT = 64,
  parameter int MAX_CNT = 60000,
  localparam int CNT_W = $clog2(MAX_CNT + 1),
  localparam int DIV_W = CNT_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  output logic             tx_out,
  output logic [DIV_W-1:0] divisor,
  output logic             locked,
  output logic             error
);
  localparam logic [7:0]  ACK_BYTE  = 8'h79;
  localparam logic [10:0] ACK_FRAME = {1'b1, ^ACK_BYTE, ACK_BYTE, 1'b0};

  typedef enum logic [2:0] {HUNT, MEAS, PAR, STOP, ACK, LOCK} st_t;
  st_t st;

  logic             rx_s1, rx_s2, rx_prev;
  logic [CNT_W-1:0] cnt, tmr;
  logic [DIV_W-1:0] div;
  logic [10:0]      sh;
  logic [3:0]       bits;

  wire              fall   = rx_prev & ~rx_s2;
  wire [CNT_W-1:0]  mdiv   = cnt >> 3;
  wire [CNT_W-1:0]  mid_tm = mdiv + (mdiv >> 1) - 1'b1;
  wire [CNT_W-1:0]  bit_tm = CNT_W'(div) - 1'b1;

  assign tx_out  = (st == ACK) ? sh[0] : 1'b1;
  assign locked  = (st == LOCK);
  assign divisor = div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1; rx_prev <= 1'b1;
      st <= HUNT; cnt <= '0; tmr <= '0; div <= '0;
      sh <= '1; bits <= '0; error <= 1'b0;
    end else begin
      rx_s1   <= rx_in;
      rx_s2   <= rx_s1;
      rx_prev <= rx_s2;
      error   <= 1'b0;
      case (st)
        HUNT: if (fall) begin
          cnt <= CNT_W'(1);
          st  <= MEAS;
        end
        MEAS: begin
          if (fall) begin
            if (cnt >= CNT_W'(MIN_CNT)) begin
              div <= mdiv[DIV_W-1:0];
              tmr <= mid_tm;
              st  <= PAR;
            end else st <= HUNT;
          end else if (cnt == CNT_W'(MAX_CNT)) st <= HUNT;
          else cnt <= cnt + 1'b1;
        end
        PAR: begin
          if (tmr != 0) tmr <= tmr - 1'b1;
          else if (rx_s2) begin tmr <= bit_tm; st <= STOP; end
          else begin error <= 1'b1; st <= HUNT; end
        end
        STOP: begin
          if (tmr != 0) tmr <= tmr - 1'b1;
          else if (rx_s2) begin
            sh <= ACK_FRAME; bits <= '0; tmr <= bit_tm; st <= ACK;
          end else begin error <= 1'b1; st <= HUNT; end
        end
        ACK: begin
          if (tmr != 0) tmr <= tmr - 1'b1;
          else if (bits == 4'd10) st <= LOCK;
          else begin
            sh   <= {1'b1, sh[10:1]};
            bits <= bits + 1'b1;
            tmr  <= bit_tm;
          end
        end
        default: ;
      endcase
    end
  end

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(divisor));
  assert_quiet_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> tx_out);
  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
  assert_err_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !locked);
  assert_div_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (int'(divisor) >= (MIN_CNT >> 3)));
endmodule

// File: tb/autobaud_sync_test.sv
module autobaud_sync_test;
  localparam int MIN_CNT = 64;
  localparam int MAX_CNT = 2000;
  localparam int DIV_W   = $clog2(MAX_CNT + 1) - 3;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1;
  logic tx_out, locked, error;
  logic [DIV_W-1:0] divisor;
  int n_chk = 0, n_bad = 0, err_cnt = 0, txlow_cnt = 0;

  always #2.5 clk = ~clk;

  autobaud_sync #(.MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT)) uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tx_out(tx_out),
    .divisor(divisor), .locked(locked), .error(error));

  always @(posedge clk) begin
    if (error) err_cnt++;
    if (!tx_out) txlow_cnt++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(logic b, int bt);
    rx_in = b;
    repeat (bt) @(negedge clk);
  endtask

  task automatic send_frame(int bt, logic par, logic stp, logic [7:0] d = 8'h7F);
    send_bit(1'b0, bt);
    for (int i = 0; i < 8; i++) send_bit(d[i], bt);
    send_bit(par, bt);
    send_bit(stp, bt);
    rx_in = 1'b1;
  endtask

  task automatic catch_reply(int bt);
    int waited = 0;
    logic [7:0] got;
    while (tx_out && waited < 40 * bt + 2000) begin
      @(negedge clk); waited++;
    end
    check("R6 reply started", int'(!tx_out), 1);
    repeat (bt / 2) @(negedge clk);
    check("R6 start bit", int'(tx_out), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bt) @(negedge clk);
      got[i] = tx_out;
    end
    check("R6 ack byte", int'(got), 8'h79);
    repeat (bt) @(negedge clk);
    check("R6 parity bit", int'(tx_out), 1);
    repeat (bt) @(negedge clk);
    check("R6 stop bit", int'(tx_out), 1);
    check("R7 locked low during stop", int'(locked), 0);
    repeat (bt) @(negedge clk);
    check("R7 locked after stop", int'(locked), 1);
  endtask

  task automatic run_good(int bt);
    fork
      send_frame(bt, 1'b1, 1'b1);
      catch_reply(bt);
    join
    check("R2 divisor", int'(divisor), bt);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 tx idle", int'(tx_out), 1);
    check("R1 locked", int'(locked), 0);
    check("R1 error", int'(error), 0);
    check("R1 divisor", int'(divisor), 0);
  endtask

  task automatic t_rates();
    do_reset(); run_good(16);
    do_reset(); run_good(40);
  endtask

  task automatic t_bad_parity();
    int e0;
    do_reset();
    e0 = err_cnt;
    send_frame(16, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    check("R3 single error pulse", err_cnt - e0, 1);
    check("R3 not locked", int'(locked), 0);
    run_good(24);
  endtask

  task automatic t_bad_stop();
    int e0;
    do_reset();
    e0 = err_cnt;
    send_frame(16, 1'b1, 1'b0);
    repeat (100) @(negedge clk);
    check("R4 single error pulse", err_cnt - e0, 1);
    check("R4 not locked", int'(locked), 0);
    run_good(16);
  endtask

  task automatic t_limits();
    int e0, t0;
    do_reset();
    e0 = err_cnt; t0 = txlow_cnt;
    send_frame(7, 1'b1, 1'b1);
    repeat (300) @(negedge clk);
    check("R5 short: no error", err_cnt - e0, 0);
    check("R5 short: tx quiet", txlow_cnt - t0, 0);
    check("R5 short: not locked", int'(locked), 0);
    send_frame(251, 1'b1, 1'b1);
    repeat (4500) @(negedge clk);
    check("R5 long: no error", err_cnt - e0, 0);
    check("R5 long: tx quiet", txlow_cnt - t0, 0);
    check("R5 long: not locked", int'(locked), 0);
    run_good(8);
    do_reset();
    run_good(250);
  endtask

  task automatic t_ignore();
    int e0, t0;
    do_reset();
    run_good(20);
    e0 = err_cnt; t0 = txlow_cnt;
    send_frame(32, 1'b1, 1'b1);
    send_frame(16, 1'b0, 1'b0);
    repeat (500) @(negedge clk);
    check("R8 divisor kept", int'(divisor), 20);
    check("R8 tx quiet", txlow_cnt - t0, 0);
    check("R8 no error", err_cnt - e0, 0);
    check("R8 still locked", int'(locked), 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_rates();
    t_bad_parity();
    t_bad_stop();
    t_limits();
    t_ignore();
    finish_run();
  end
endmodule